// File: doc/BRIEF.md
# Edge-Count Tamper Loop Monitor

The block sends a train of pulses out on a pin that runs through a tamper loop, a conductive path that opens when an enclosure is breached. The loop returns to a second pin. The block divides time into check windows of a configurable length. Within each window it counts the rising edges it launched and the rising edges that came back. When the window ends, the two tallies are compared, and any difference latches a tamper flag.

The pulses come from a small sequencer. It emits bursts of pulses, with a programmable half period, separated by a programmable gap. The burst size is either a fixed setting or a value taken from a 32-bit LFSR, which picks a new size for every burst. The expected tally is simply the count of edges that were actually launched in the window, so randomised bursts need no separate prediction.

During the last few cycles of every window no new pulse is launched. This lets the final returned edge pass through the input synchroniser before the comparison. A cut loop is therefore reported at the end of the window in which it occurs, and no earlier.

Top module: `tamper_edge_monitor`

## Requirements
- R1: After a synchronous reset, `tamper`, `check_done`, `loop_out`, `tx_count` and `rx_count` are all 0. A reset also clears a latched tamper flag.
- R2: Window cycles are numbered from 0, where cycle 0 is the first cycle with `enable` high (or the cycle after a check). In fixed mode, a burst starts in window cycle 0. Each pulse drives `loop_out` high for `half_period` cycles and then low for `half_period` cycles. A burst has `burst_len` pulses and is followed by `gap_len` low cycles before the next burst. The rising edge of a pulse launched at cycle c appears at cycle c+1. `tx_count` reports the rising edges launched during the window.
- R3: When `loop_in` follows `loop_out`, every window ends with `rx_count` equal to `tx_count` and `tamper` staying 0. This includes an edge launched just before the guard band.
- R4: With the loop open, `tamper` is still 0 in the last cycle (cycle W-1) of the first window. It becomes 1 in the next cycle, together with a one-cycle `check_done` pulse.
- R5: An extra rising edge on `loop_in` that was not launched makes `rx_count` exceed `tx_count`, and sets `tamper` at the end of that window.
- R6: `tamper` stays 1 until `tamper_clear` is asserted. When a mismatching check and `tamper_clear` occur in the same cycle, the check wins.
- R7: With `rand_mode`=1, each burst has (LFSR low 3 bits)+1 pulses. The LFSR advances once per burst and is loaded from `seed` (0 loads 1) by `seed_load`. On an intact loop, `tamper` stays 0, and burst sizes vary from window to window.
- R8: No pulse is launched in the last 4 cycles of a window. A pulse in progress is cut short, so `loop_out` is 0 in the last 3 cycles of every window.
- R9: While `enable` is 0, `loop_out` stays 0 and no `check_done` occurs. Raising `enable` starts a new window at cycle 0.
- R10: A `half_period` of 0 acts as 1, a `burst_len` of 0 acts as 1, and a `window_len` below 6 acts as 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the windows and the pulse sequencer |
| rand_mode | input | 1 | 1: burst size taken from the LFSR |
| half_period | input | PER_W | Cycles of each high and of each low half of a pulse |
| burst_len | input | WIN_W | Pulses per burst in fixed mode |
| gap_len | input | PER_W | Low cycles between bursts |
| seed | input | LFSR_W | LFSR load value |
| seed_load | input | 1 | Loads `seed` into the LFSR |
| window_len | input | WIN_W | Check window length in cycles |
| tamper_clear | input | 1 | Clears the latched tamper flag |
| loop_in | input | 1 | Return side of the tamper loop |
| loop_out | output | 1 | Drive side of the tamper loop |
| tamper | output | 1 | Latched tamper flag |
| tx_count | output | WIN_W | Edges launched in the last completed window |
| rx_count | output | WIN_W | Edges received in the last completed window |
| check_done | output | 1 | One-cycle pulse after each window comparison |

## Verification
Internal state that is wrong shows up only at a window boundary. This is the one point where `tx_count`, `rx_count` and `tamper` change, so a fault appears at most one window length after it arises. A sequencer fault (a wrong phase counter, burst size or gap) gives a `tx_count` that differs from the value computed from the schedule. A lost or extra synchroniser edge gives an `rx_count` that differs from `tx_count` on an intact loop. A window counter that is off by one moves the flag or the `check_done` pulse by a cycle, which the latency checks at cycles W-1 and W detect. A guard band that is too short loses the final returned edge and raises a false tamper flag.

// File: rtl/tem_pkg.sv
package tem_pkg;
  typedef enum logic [1:0] {
    GEN_IDLE,
    GEN_HIGH,
    GEN_LOW,
    GEN_GAP
  } gen_state_t;

  // flops between loop_in and the edge detector
  localparam int SYNC_STAGES = 2;
  // no launches in the last GUARD cycles of a window
  localparam int GUARD = SYNC_STAGES + 2;
  localparam int MIN_WINDOW = GUARD + 2;
endpackage

// File: rtl/tem_pattern_gen.sv
module tem_pattern_gen
  import tem_pkg::*;
#(
  parameter int PER_W = 8,
  parameter int GAP_W = 8,
  parameter int CNT_W = 16,
  parameter int LFSR_W = 32,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003,
  parameter int RAND_BITS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              rand_mode,
  input  logic [PER_W-1:0]  half_period,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [GAP_W-1:0]  gap_len,
  input  logic [LFSR_W-1:0] seed,
  input  logic              seed_load,
  output logic              drive,
  output logic              rise
);
  localparam int PH_W = (PER_W > GAP_W) ? PER_W : GAP_W;

  gen_state_t        state;
  logic [PH_W-1:0]   phase;
  logic [CNT_W-1:0]  left;
  logic [LFSR_W-1:0] lfsr;

  logic [PER_W-1:0] half_eff;
  logic [CNT_W-1:0] fixed_n;
  logic [CNT_W-1:0] rand_n;
  logic [CNT_W-1:0] burst_n;
  logic             load_burst;
  logic             next_pulse;
  logic             phase_end;

  assign half_eff  = (half_period == '0) ? PER_W'(1) : half_period;
  assign fixed_n   = (burst_len == '0) ? CNT_W'(1) : burst_len;
  assign rand_n    = {{(CNT_W-RAND_BITS){1'b0}}, lfsr[RAND_BITS-1:0]} + CNT_W'(1);
  assign burst_n   = rand_mode ? rand_n : fixed_n;
  assign phase_end = (phase == '0);

  assign load_burst = run && ((state == GEN_IDLE) ||
                              (state == GEN_GAP && phase_end) ||
                              (state == GEN_LOW && phase_end && left <= CNT_W'(1) && gap_len == '0));
  assign next_pulse = run && state == GEN_LOW && phase_end && left > CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= GEN_IDLE;
      drive <= 1'b0;
      rise  <= 1'b0;
      phase <= '0;
      left  <= '0;
    end else begin
      rise <= 1'b0;
      if (!run) begin
        state <= GEN_IDLE;
        drive <= 1'b0;
      end else if (load_burst || next_pulse) begin
        state <= GEN_HIGH;
        drive <= 1'b1;
        rise  <= 1'b1;
        phase <= PH_W'(half_eff) - PH_W'(1);
        left  <= load_burst ? burst_n : left - CNT_W'(1);
      end else begin
        case (state)
          GEN_HIGH: begin
            if (phase_end) begin
              state <= GEN_LOW;
              drive <= 1'b0;
              phase <= PH_W'(half_eff) - PH_W'(1);
            end else begin
              phase <= phase - PH_W'(1);
            end
          end
          GEN_LOW: begin
            if (phase_end) begin
              state <= GEN_GAP;
              phase <= PH_W'(gap_len) - PH_W'(1);
            end else begin
              phase <= phase - PH_W'(1);
            end
          end
          GEN_GAP: phase <= phase - PH_W'(1);
          default: state <= GEN_IDLE;
        endcase
      end
    end
  end

  // Galois LFSR, one step per burst in random mode
  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr <= LFSR_W'(1);
    end else if (seed_load) begin
      lfsr <= (seed == '0) ? LFSR_W'(1) : seed;
    end else if (load_burst && rand_mode) begin
      lfsr <= lfsr[0] ? ((lfsr >> 1) ^ LFSR_TAPS) : (lfsr >> 1);
    end
  end

  assert_abort_low_R8: assert property (@(posedge clk) disable iff (rst)
    !run |=> !drive);
  assert_rise_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
  assert_rise_marks_edge_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(drive) |-> rise);
  assert_lfsr_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);
endmodule

// File: rtl/tem_return_sync.sv
module tem_return_sync
  import tem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic loop_in,
  output logic rise
);
  logic [SYNC_STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst || !enable) shreg <= '0;
    else                shreg <= {shreg[SYNC_STAGES-1:0], loop_in};
  end

  assign rise = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];

  assert_single_rise_R5: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/tem_tally.sv
module tem_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || restart) count <= '0;
    else if (inc)       count <= count + CNT_W'(1);
  end

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (inc && !restart) |-> (count != '1));
endmodule

// File: rtl/tem_window_check.sv
module tem_window_check
  import tem_pkg::*;
#(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [WIN_W-1:0] window_len,
  input  logic [WIN_W-1:0] tx_tally,
  input  logic [WIN_W-1:0] rx_tally,
  input  logic             rx_rise,
  input  logic             tamper_clear,
  output logic             run,
  output logic             win_last,
  output logic             tamper,
  output logic [WIN_W-1:0] tx_count,
  output logic [WIN_W-1:0] rx_count,
  output logic             check_done
);
  localparam logic [WIN_W-1:0] MIN_LEN = WIN_W'(MIN_WINDOW);
  localparam logic [WIN_W-1:0] GUARD_LEN = WIN_W'(GUARD);

  logic [WIN_W-1:0] win_cnt;
  logic [WIN_W-1:0] win_eff;
  logic [WIN_W-1:0] rx_final;
  logic             mismatch;

  assign win_eff  = (window_len < MIN_LEN) ? MIN_LEN : window_len;
  assign win_last = enable && (win_cnt >= win_eff - WIN_W'(1));
  assign run      = enable && (win_cnt < win_eff - GUARD_LEN);
  assign rx_final = rx_tally + WIN_W'(rx_rise);
  assign mismatch = tx_tally != rx_final;

  always_ff @(posedge clk) begin
    if (rst || !enable || win_last) win_cnt <= '0;
    else                            win_cnt <= win_cnt + WIN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tamper     <= 1'b0;
      tx_count   <= '0;
      rx_count   <= '0;
      check_done <= 1'b0;
    end else begin
      check_done <= win_last;
      if (win_last) begin
        tx_count <= tx_tally;
        rx_count <= rx_final;
      end
      if (win_last && mismatch) tamper <= 1'b1;
      else if (tamper_clear)    tamper <= 1'b0;
    end
  end

  assert_tamper_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (tamper && !tamper_clear) |=> tamper);
  assert_flag_at_check_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(tamper) |-> check_done);
  assert_mismatch_flags_R5: assert property (@(posedge clk) disable iff (rst)
    (check_done && tx_count != rx_count) |-> tamper);
  assert_quiet_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !check_done);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    check_done |=> !check_done);
endmodule

// File: rtl/tamper_edge_monitor.sv
module tamper_edge_monitor #(
  parameter int PER_W = 8,
  parameter int WIN_W = 16,
  parameter int LFSR_W = 32,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003,
  parameter int RAND_BITS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              rand_mode,
  input  logic [PER_W-1:0]  half_period,
  input  logic [WIN_W-1:0]  burst_len,
  input  logic [PER_W-1:0]  gap_len,
  input  logic [LFSR_W-1:0] seed,
  input  logic              seed_load,
  input  logic [WIN_W-1:0]  window_len,
  input  logic              tamper_clear,
  input  logic              loop_in,
  output logic              loop_out,
  output logic              tamper,
  output logic [WIN_W-1:0]  tx_count,
  output logic [WIN_W-1:0]  rx_count,
  output logic              check_done
);
  // tallies share the window width, so one edge per two cycles never wraps
  localparam int CNT_W = WIN_W;

  logic             run;
  logic             win_last;
  logic             tx_rise;
  logic             rx_rise;
  logic             tally_restart;
  logic [CNT_W-1:0] tx_tally;
  logic [CNT_W-1:0] rx_tally;

  assign tally_restart = win_last || !enable;

  tem_pattern_gen #(
    .PER_W(PER_W), .GAP_W(PER_W), .CNT_W(CNT_W),
    .LFSR_W(LFSR_W), .LFSR_TAPS(LFSR_TAPS), .RAND_BITS(RAND_BITS)
  ) u_gen (
    .clk(clk), .rst(rst), .run(run), .rand_mode(rand_mode),
    .half_period(half_period), .burst_len(burst_len), .gap_len(gap_len),
    .seed(seed), .seed_load(seed_load), .drive(loop_out), .rise(tx_rise)
  );

  tem_return_sync u_sync (
    .clk(clk), .rst(rst), .enable(enable), .loop_in(loop_in), .rise(rx_rise)
  );

  tem_tally #(.CNT_W(CNT_W)) u_tx_tally (
    .clk(clk), .rst(rst), .restart(tally_restart), .inc(tx_rise), .count(tx_tally)
  );

  tem_tally #(.CNT_W(CNT_W)) u_rx_tally (
    .clk(clk), .rst(rst), .restart(tally_restart), .inc(rx_rise), .count(rx_tally)
  );

  tem_window_check #(.WIN_W(WIN_W)) u_check (
    .clk(clk), .rst(rst), .enable(enable), .window_len(window_len),
    .tx_tally(tx_tally), .rx_tally(rx_tally), .rx_rise(rx_rise),
    .tamper_clear(tamper_clear), .run(run), .win_last(win_last),
    .tamper(tamper), .tx_count(tx_count), .rx_count(rx_count),
    .check_done(check_done)
  );
endmodule

// File: tb/tamper_edge_monitor_test.sv
module tamper_edge_monitor_test;
  localparam int GUARD_C = 4;
  localparam int MINW_C = 6;
  localparam int NV = 6;
  localparam int VH[NV] = '{1, 3, 0, 2, 5, 4};
  localparam int VN[NV] = '{4, 2, 0, 3, 10, 1};
  localparam int VG[NV] = '{6, 0, 5, 10, 0, 20};
  localparam int VW[NV] = '{40, 50, 30, 3, 200, 100};

  logic clk = 0, rst = 1, enable = 0, rand_mode = 0, seed_load = 0, tamper_clear = 0;
  logic [7:0] half_period = 1, gap_len = 0;
  logic [15:0] burst_len = 1, window_len = 40;
  logic [31:0] seed = 0;
  logic brk = 0, glitch = 0;
  logic loop_in, loop_out, tamper, check_done;
  logic [15:0] tx_count, rx_count;
  int checks = 0, errors = 0;

  assign loop_in = brk ? 1'b0 : (loop_out | glitch);

  always #10 clk = ~clk;

  tamper_edge_monitor uut (
    .clk(clk), .rst(rst), .enable(enable), .rand_mode(rand_mode),
    .half_period(half_period), .burst_len(burst_len), .gap_len(gap_len),
    .seed(seed), .seed_load(seed_load), .window_len(window_len),
    .tamper_clear(tamper_clear), .loop_in(loop_in), .loop_out(loop_out),
    .tamper(tamper), .tx_count(tx_count), .rx_count(rx_count),
    .check_done(check_done)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_rises(int h, int n, int g, int w);
    int he = (h < 1) ? 1 : h;
    int ne = (n < 1) ? 1 : n;
    int we = (w < MINW_C) ? MINW_C : w;
    int last = we - GUARD_C - 1;
    int cnt = 0;
    int t = 0;
    while (t <= last) begin
      for (int k = 0; k < ne; k++) if (t + 2 * he * k <= last) cnt++;
      t += 2 * he * ne + g;
    end
    return cnt;
  endfunction

  task automatic start(int h, int n, int g, int w, logic rm);
    @(negedge clk);
    enable = 0;
    half_period = 8'(h); burst_len = 16'(n); gap_len = 8'(g);
    window_len = 16'(w); rand_mode = rm;
    tamper_clear = 1;
    @(negedge clk);
    tamper_clear = 0;
    enable = 1;
  endtask

  task automatic wait_check();
    do @(negedge clk); while (!check_done);
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int prev_tx;
    int distinct;
    int seen;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 tamper after reset", tamper, 0);
    chk("R1 check_done after reset", check_done, 0);
    chk("R1 loop_out after reset", loop_out, 0);
    chk("R1 tx_count after reset", tx_count, 0);
    chk("R1 rx_count after reset", rx_count, 0);

    // table of fixed patterns on an intact loop
    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = (i == 2 || i == 3) ? "R10" : "R2";
      start(VH[i], VN[i], VG[i], VW[i], 1'b0);
      for (int wdx = 0; wdx < 2; wdx++) begin
        wait_check();
        chk({tg, " tx_count"}, tx_count, exp_rises(VH[i], VN[i], VG[i], VW[i]));
        chk("R3 rx equals tx", rx_count, tx_count);
        chk("R3 no tamper on intact loop", tamper, 0);
      end
    end

    // R8 guard band: W=41, h=6, last launch at cycle 36
    start(6, 50, 0, 41, 1'b0);
    repeat (37) @(negedge clk);
    chk("R8 loop_out high at cycle 37", loop_out, 1);
    for (int c = 38; c <= 40; c++) begin
      @(negedge clk);
      chk("R8 loop_out low in guard", loop_out, 0);
    end
    @(negedge clk);
    chk("R8 check_done at window end", check_done, 1);
    chk("R8 tx includes cut pulse", tx_count, 4);
    chk("R3 late edge received", rx_count, 4);
    chk("R3 no tamper after guard", tamper, 0);

    // R4 open loop latency
    brk = 1;
    start(1, 4, 6, 40, 1'b0);
    repeat (39) @(negedge clk);
    chk("R4 no flag before window end", tamper, 0);
    @(negedge clk);
    chk("R4 flag one cycle after window", tamper, 1);
    chk("R4 check_done with flag", check_done, 1);
    chk("R4 rx_count on open loop", rx_count, 0);
    chk("R4 tx_count on open loop", tx_count, 12);
    brk = 0;

    // R5 extra edge in the gap (cycles 10,11)
    start(1, 4, 6, 40, 1'b0);
    repeat (10) @(negedge clk);
    glitch = 1;
    repeat (2) @(negedge clk);
    glitch = 0;
    wait_check();
    chk("R5 rx_count with extra edge", rx_count, 13);
    chk("R5 tx_count with extra edge", tx_count, 12);
    chk("R5 tamper on extra edge", tamper, 1);

    // R6 sticky and set-over-clear
    wait_check();
    chk("R6 flag stays set", tamper, 1);
    chk("R6 later window matches", rx_count, tx_count);
    brk = 1;
    tamper_clear = 1;
    wait_check();
    chk("R6 mismatch wins over clear", tamper, 1);
    tamper_clear = 0;
    brk = 0;
    wait_check();
    chk("R6 flag held without clear", tamper, 1);
    tamper_clear = 1;
    @(negedge clk);
    tamper_clear = 0;
    chk("R6 flag cleared", tamper, 0);
    wait_check();
    chk("R6 stays clear on intact loop", tamper, 0);

    // R7 random bursts
    @(negedge clk);
    enable = 0;
    seed = 32'h1234_5678;
    seed_load = 1;
    @(negedge clk);
    seed_load = 0;
    start(1, 0, 3, 60, 1'b1);
    prev_tx = -1;
    distinct = 0;
    for (int wdx = 0; wdx < 4; wdx++) begin
      wait_check();
      chk("R7 rx equals tx in random mode", rx_count, tx_count);
      chk("R7 no tamper in random mode", tamper, 0);
      if (int'(tx_count) != prev_tx) distinct++;
      prev_tx = int'(tx_count);
    end
    chk("R7 burst sizes vary", (distinct >= 2) ? 1 : 0, 1);

    // R9 disabled is quiet
    @(negedge clk);
    enable = 0;
    seen = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (check_done || loop_out) seen++;
    end
    chk("R9 no activity while disabled", seen, 0);

    // R1 reset clears a latched flag
    brk = 1;
    start(1, 1, 0, 10, 1'b0);
    wait_check();
    chk("R1 flag set before reset", tamper, 1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 reset clears flag", tamper, 0);
    chk("R1 reset clears tx_count", tx_count, 0);
    brk = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule